// File: doc/BRIEF.md
# Packet-Gated Receive Byte Queue

This block sits between the holding register of a serial receiver and a host bus. Received bytes go into a four-entry queue and are grouped into packets whose length comes from a 16-bit length input. The queue is closed to the host until it has something finished to offer. That happens in one of two cases: the queue has filled, or the final byte of a packet has arrived. Either event sets a status bit and can pull the active-low interrupt line.

Once an event occurs, the queue is frozen against the receiver. The host empties the queue one byte per read strobe, oldest byte first. Only when the queue is empty does the queue accept bytes from the receiver again. While the queue is frozen, the receiver sees a stall. If a second byte arrives while the holding register is still occupied, that byte is dropped and an overrun pulse is raised.

Top module: `pkt_gate_rxq`

## Requirements
- R1: After reset, irq_n is 1, both status bits are 0, rx_stall is 0, rd_valid is 0 and overrun is 0.
- R2: With a packet length from 1 to 3, status and interrupt stay idle until the last byte of the packet is in the queue. At that point the packet-end flag (sts_pkt_end) becomes 1, sts_full stays 0 and irq_n drops to 0 when irq_en is 1.
- R3: With a packet length of 4 or more, the fourth queued byte of a group sets sts_full to 1. If that byte is not the packet's last byte, sts_pkt_end stays 0.
- R4: With a packet length of 4 or more that is not a multiple of 4, the last byte of the trailing partial group sets sts_pkt_end only.
- R5: With a packet length that is a multiple of 4, the last byte of the packet sets both sts_full and sts_pkt_end.
- R6: Until an event has occurred, host_rd gives no rd_valid and removes nothing from the queue.
- R7: After an event, each host_rd pulse gives one byte on rd_data with rd_valid on the next cycle, in arrival order.
- R8: rx_stall is 1 from the event until the read that empties the queue. During that time a byte held in the receive register does not enter the queue.
- R9: A host_ack pulse clears both status bits and returns irq_n to 1. rx_stall stays 1 until the queue is drained.
- R10: With irq_en at 0, an event still sets the status bits but irq_n remains 1.
- R11: A packet length of 0 behaves as a length of 1.
- R12: A byte strobe that arrives while the holding register is occupied and cannot move out is dropped. overrun is 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| blk_len | input | 16 | Packet length in bytes (0 means 1) |
| irq_en | input | 1 | Interrupt enable |
| host_rd | input | 1 | Host read strobe, one byte per pulse |
| host_ack | input | 1 | Host acknowledge of the current event |
| rd_data | output | 8 | Byte read from the queue |
| rd_valid | output | 1 | rd_data is valid this cycle |
| sts_pkt_end | output | 1 | Last byte of a packet is queued |
| sts_full | output | 1 | Queue reached four bytes |
| irq_n | output | 1 | Active-low interrupt |
| rx_stall | output | 1 | Transfers from the holding register are held off |
| overrun | output | 1 | One-cycle pulse: a byte was dropped |

## Verification
The hardest situation to reach is a byte stuck in the holding register while the queue is frozen, followed by one more strobe that must be dropped. The stimulus sets a length of 0, so the first byte freezes the queue. It then sends two more bytes without reading. The bench expects the middle byte to become a packet of its own once the queue drains, and the last byte never to appear on rd_data.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;
  typedef struct packed {
    logic full;
    logic pkt_end;
  } evt_t;
endpackage

// File: rtl/pkt_gate_hold.sv
module pkt_gate_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         block,
  output logic         xfer,
  output logic [W-1:0] hold_data,
  output logic         overrun
);
  logic hold_full;

  assign xfer = hold_full & ~block;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      overrun   <= 1'b0;
    end else begin
      overrun <= rx_valid & hold_full & ~xfer;
      if (rx_valid && (!hold_full || xfer)) begin
        hold_full <= 1'b1;
        hold_data <= rx_byte;
      end else if (xfer) begin
        hold_full <= 1'b0;
      end
    end
  end

  assert_overrun_cause_R12: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(rx_valid) && $past(block));
endmodule

// File: rtl/pkt_gate_queue.sv
module pkt_gate_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en && !rd_en |-> count < CW'(DEPTH));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0);
endmodule

// File: rtl/pkt_gate_ctrl.sv
module pkt_gate_ctrl
  import pkt_gate_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic [CW-1:0] q_count,
  input  logic [LW-1:0] blk_len,
  input  logic          irq_en,
  input  logic          host_rd,
  input  logic          host_ack,
  output logic          pop,
  output logic          frozen,
  output evt_t          sts,
  output logic          irq_n
);
  logic [LW-1:0] remain, cur;
  evt_t          evt, sts_d;
  logic          last_pop;

  assign cur      = (remain != '0) ? remain : ((blk_len == '0) ? LW'(1) : blk_len);
  assign evt.pkt_end = xfer & (cur == LW'(1));
  assign evt.full    = xfer & (q_count == CW'(DEPTH - 1));
  assign pop      = host_rd & frozen & (q_count != '0);
  assign last_pop = pop & (q_count == CW'(1));

  always_comb begin
    sts_d = sts;
    if (evt.pkt_end || evt.full) sts_d = evt;
    else if (host_ack || last_pop) sts_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      frozen <= 1'b0;
      sts    <= '0;
      irq_n  <= 1'b1;
    end else begin
      sts   <= sts_d;
      irq_n <= ~(irq_en & (sts_d.pkt_end | sts_d.full));
      if (xfer) remain <= cur - 1'b1;
      if (evt.pkt_end || evt.full) frozen <= 1'b1;
      else if (last_pop) frozen <= 1'b0;
    end
  end

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    host_ack && frozen |=> !sts.pkt_end && !sts.full);
  assert_status_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (sts.pkt_end || sts.full) |-> frozen);
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (sts.pkt_end || sts.full));
  assert_reads_locked_R6: assert property (@(posedge clk) disable iff (rst)
    !frozen |=> $past(q_count) == '0 || q_count >= $past(q_count));
endmodule

// File: rtl/pkt_gate_rxq.sv
module pkt_gate_rxq
  import pkt_gate_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_byte,
  input  logic [LW-1:0] blk_len,
  input  logic          irq_en,
  input  logic          host_rd,
  input  logic          host_ack,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          sts_pkt_end,
  output logic          sts_full,
  output logic          irq_n,
  output logic          rx_stall,
  output logic          overrun
);
  logic          xfer, frozen, pop;
  logic [W-1:0]  hold_data;
  logic [CW-1:0] q_count;
  evt_t          sts;

  pkt_gate_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .block(frozen), .xfer(xfer), .hold_data(hold_data), .overrun(overrun));

  pkt_gate_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .wr_en(xfer), .wr_data(hold_data), .rd_en(pop),
    .rd_data(rd_data), .rd_valid(rd_valid), .count(q_count));

  pkt_gate_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .xfer(xfer), .q_count(q_count), .blk_len(blk_len),
    .irq_en(irq_en), .host_rd(host_rd), .host_ack(host_ack), .pop(pop),
    .frozen(frozen), .sts(sts), .irq_n(irq_n));

  assign rx_stall    = frozen;
  assign sts_pkt_end = sts.pkt_end;
  assign sts_full    = sts.full;

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
    rx_stall |=> q_count <= $past(q_count));
endmodule

// File: tb/pkt_gate_rxq_test.sv
module pkt_gate_rxq_test;
  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 1'b0, irq_en = 1'b1, host_rd = 1'b0, host_ack = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [15:0] blk_len = 16'd2;
  logic [7:0] rd_data;
  logic rd_valid, sts_pkt_end, sts_full, irq_n, rx_stall, overrun;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] expq[$];

  always #10 clk = ~clk;

  pkt_gate_rxq uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit kept);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    if (kept) expq.push_back(b);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
    end
  endtask

  task automatic chk_sts(input string req, input logic [1:0] exp, input logic exp_irq_n);
    check({sts_full, sts_pkt_end} == exp, req, {sts_full, sts_pkt_end}, exp);
    check(irq_n == exp_irq_n, req, irq_n, exp_irq_n);
  endtask

  // scoreboard monitor: R7 order
  always @(negedge clk) if (!rst && rd_valid) begin
    if (expq.size() == 0) check(0, "R7 unexpected read", rd_data, 0);
    else begin
      logic [7:0] e;
      e = expq.pop_front();
      check(rd_data == e, "R7 data order", rd_data, e);
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_sts("R1", 2'b00, 1'b1);
    check(rx_stall == 0 && rd_valid == 0 && overrun == 0, "R1", rx_stall, 0);

    // short packet, length 2
    send(8'hA1, 1); @(negedge clk);
    chk_sts("R2 early", 2'b00, 1'b1);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    check(rd_valid == 0, "R6 locked read", rd_valid, 0);
    send(8'hA2, 1); @(negedge clk);
    chk_sts("R2", 2'b01, 1'b0);
    check(rx_stall == 1, "R8 stall", rx_stall, 1);
    drain(2);
    chk_sts("R8 drained", 2'b00, 1'b1);
    check(rx_stall == 0, "R8 released", rx_stall, 0);

    // length 6: full then partial end
    blk_len = 16'd6;
    for (int i = 0; i < 4; i++) send(8'hB0 + 8'(i), 1);
    @(negedge clk);
    chk_sts("R3", 2'b10, 1'b0);
    drain(4);
    send(8'hB4, 1); send(8'hB5, 1); @(negedge clk);
    chk_sts("R4", 2'b01, 1'b0);
    drain(2);

    // length 8: multiple of 4
    blk_len = 16'd8;
    for (int i = 0; i < 4; i++) send(8'hC0 + 8'(i), 1);
    @(negedge clk);
    chk_sts("R3 first group", 2'b10, 1'b0);
    drain(4);
    for (int i = 4; i < 8; i++) send(8'hC0 + 8'(i), 1);
    @(negedge clk);
    chk_sts("R5", 2'b11, 1'b0);
    drain(4);

    // interrupt disabled, then ack
    irq_en = 1'b0; blk_len = 16'd1;
    send(8'hD0, 1); @(negedge clk);
    chk_sts("R10", 2'b01, 1'b1);
    irq_en = 1'b1; @(negedge clk); @(negedge clk);
    check(irq_n == 0, "R10 enable", irq_n, 0);
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    chk_sts("R9", 2'b00, 1'b1);
    check(rx_stall == 1, "R9 stall kept", rx_stall, 1);
    drain(1);
    check(rx_stall == 0, "R9 released", rx_stall, 0);

    // length 0 acts as 1, holding register and overrun
    blk_len = 16'd0;
    send(8'hE0, 1); @(negedge clk);
    chk_sts("R11", 2'b01, 1'b0);
    send(8'hE1, 1);
    check(rx_stall == 1, "R8 held", rx_stall, 1);
    check(overrun == 0, "R12 no drop", overrun, 0);
    send(8'hE2, 0);
    check(overrun == 1, "R12 drop", overrun, 1);
    drain(1);
    @(negedge clk); @(negedge clk);
    chk_sts("R11 next packet", 2'b01, 1'b0);
    drain(1);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R12 dropped byte absent", expq.size(), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule